// File: doc/BRIEF.md
# Indexed Configuration RAM with Running Checksum

This block is a 64-byte non-volatile-style configuration store reached through two byte-wide ports. The index port holds a 7-bit pointer; the data port reads or writes the byte that pointer selects. A host first writes the index port, then issues data-port reads or writes. Only the low six index bits pick a location, so indexes 64 to 127 alias onto 0 to 63.

A 16-bit checksum covers locations 0x10 to 0x2C inclusive. The high byte lives at 0x2E and the low byte at 0x2F. The checksum is kept current in hardware: each write into the covered range takes the old byte out of a running sum and adds the new byte in. No scan of the range is needed. The running sum is already correct out of reset, because the reset image and its sum are computed at elaboration.

A small controller is built around a two-state machine. `S_IDLE` waits for a strobe. `S_RESP` is the single cycle in which `rdy` is high and `rdata` carries the result of the previous cycle's read. It has two transitions:
- **T_READ** (`S_IDLE`/`S_RESP` → `S_RESP`) is taken on a read strobe without a write strobe.
- **T_DONE** (`S_RESP`/`S_IDLE` → `S_IDLE`) is taken on any other cycle.

Top module: `cfgram_top`

## Requirements
- R1: During and right after reset, `rdy` is 0, `rdata` is 0x00 and the stored index is 0.
- R2: A write to the index port (`sel`=0) stores `wdata[6:0]`. A read of the index port returns the stored index with bit 7 clear.
- R3: Data-port accesses (`sel`=1) address location `index[5:0]`. For example, index 0xC5 stores 0x45, and data accesses with that index reach location 0x05.
- R4: Reset contents are as follows. Location 0x0A holds 0x26, 0x0B holds 0x02, 0x0C holds 0x50 and 0x0D holds 0x80. Each location a in 0x10..0x2C holds (3·a+1) mod 256. Every other location holds 0x00, except the two checksum bytes.
- R5: Out of reset, 0x2E holds the high byte and 0x2F the low byte of the 16-bit sum of locations 0x10..0x2C (0x0A4F, giving 0x0A and 0x4F).
- R6: A data write into 0x10..0x2C updates 0x2E/0x2F on the same clock edge that stores the byte. The next read returns the new sum.
- R7: A direct data write to 0x2E or 0x2F is stored and reads back. The next write into 0x10..0x2C replaces both bytes with the true sum.
- R8: A data write outside 0x10..0x2C leaves 0x2E and 0x2F unchanged.
- R9: A read strobe without a write strobe, sampled at edge k, raises `rdy` for exactly one cycle after edge k, with the result on `rdata`. Back-to-back reads give back-to-back results.
- R10: In any cycle not preceded by a lone read strobe, `rdy` is 0 and `rdata` keeps its last value.
- R11: If read and write strobes are both high, the write is performed and no read response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Port select: 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rdy` is 1 |
| rdy | output | 1 | Read result valid |

## Verification
A read strobe sampled at one rising edge produces its result on `rdata` with `rdy` high after that edge. The bench therefore expects each result at the falling edge one cycle after it raised the strobe. Memory and checksum effects of a write land on the edge that samples the strobe, so a read issued in the very next cycle already sees them. The driver pushes each expected byte into a queue when it raises a read strobe, and a monitor pops and compares on every falling edge where `rdy` is high. The absence of a response (R10, R11) is checked one falling edge after the strobe.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;

    localparam int BYTE_W   = 8;
    localparam int LOC_BITS = 6;
    localparam int IDX_BITS = 7;
    localparam int DEPTH    = 1 << LOC_BITS;
    localparam int SUM_W    = 2 * BYTE_W;

    localparam int SUM_FIRST = 'h10;
    localparam int SUM_LAST  = 'h2C;
    localparam int CK_HI     = 'h2E;
    localparam int CK_LO     = 'h2F;

    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [LOC_BITS-1:0] loc_t;
    typedef logic [IDX_BITS-1:0] idx_t;
    typedef logic [SUM_W-1:0]    sum_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } rd_state_e;

    function automatic byte_t fill_byte(input int a);
        byte_t v;
        unique case (a)
            'h0A:    v = 8'h26;
            'h0B:    v = 8'h02;
            'h0C:    v = 8'h50;
            'h0D:    v = 8'h80;
            default: v = (a >= SUM_FIRST && a <= SUM_LAST) ? byte_t'((3 * a + 1) % 256) : '0;
        endcase
        return v;
    endfunction

    function automatic sum_t fill_sum();
        sum_t s = '0;
        for (int a = SUM_FIRST; a <= SUM_LAST; a++)
            s = s + sum_t'(fill_byte(a));
        return s;
    endfunction

    function automatic byte_t boot_byte(input int a);
        sum_t s = fill_sum();
        if (a == CK_HI) return s[SUM_W-1:BYTE_W];
        if (a == CK_LO) return s[BYTE_W-1:0];
        return fill_byte(a);
    endfunction

endpackage

// File: rtl/cfgram_store.sv
module cfgram_store
    import cfgram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  loc_t  addr,
    input  byte_t wbyte,
    output byte_t rbyte
);
    byte_t mem_q [DEPTH];
    sum_t  sum_q;
    sum_t  sum_n;
    logic  in_range;

    assign rbyte    = mem_q[addr];
    assign in_range = (int'(addr) >= SUM_FIRST) && (int'(addr) <= SUM_LAST);
    assign sum_n    = sum_q - sum_t'(mem_q[addr]) + sum_t'(wbyte);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= boot_byte(i);
            sum_q <= fill_sum();
        end else if (we) begin
            mem_q[addr] <= wbyte;
            if (in_range) begin
                sum_q        <= sum_n;
                mem_q[CK_HI] <= sum_n[SUM_W-1:BYTE_W];
                mem_q[CK_LO] <= sum_n[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cfgram_ctrl.sv
module cfgram_ctrl
    import cfgram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  logic  wr_en,
    input  logic  rd_en,
    input  byte_t wdata,
    input  byte_t mem_byte,
    output logic  mem_we,
    output loc_t  mem_addr,
    output byte_t rdata,
    output logic  rdy
);
    rd_state_e state_q, state_n;
    idx_t      idx_q;
    byte_t     rdata_q;
    logic      rd_go;

    assign rd_go    = rd_en && !wr_en;
    assign mem_we   = wr_en && sel;
    assign mem_addr = idx_q[LOC_BITS-1:0];

    always_comb begin
        state_n = S_IDLE;
        unique case (state_q)
            S_IDLE:  state_n = rd_go ? S_RESP : S_IDLE;
            S_RESP:  state_n = rd_go ? S_RESP : S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_en && !sel)
                idx_q <= wdata[IDX_BITS-1:0];
            if (rd_go)
                rdata_q <= sel ? mem_byte : byte_t'(idx_q);
        end
    end

    always_comb begin
        rdy   = 1'b0;
        rdata = rdata_q;
        unique case (state_q)
            S_IDLE:  rdy = 1'b0;
            S_RESP:  rdy = 1'b1;
            default: rdy = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgram_top.sv
module cfgram_top
    import cfgram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              rdy
);
    logic  mem_we;
    loc_t  mem_addr;
    byte_t mem_byte;

    cfgram_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .mem_byte (mem_byte),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .rdata    (rdata),
        .rdy      (rdy)
    );

    cfgram_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wbyte (wdata),
        .rbyte (mem_byte)
    );
endmodule

// File: rtl/cfgram_checker.sv
module cfgram_checker
    import cfgram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rdata,
    input logic              rdy
);
    p_rdy_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rdy);

    p_no_spurious_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> !rdy);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata));

    p_idx_msb_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !sel) |=> (rdata[BYTE_W-1] == 1'b0));

    p_collide_no_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rdy);
endmodule

bind cfgram_top cfgram_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .rdy   (rdy)
);

// File: tb/test_cfgram_top.sv
module test_cfgram_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdy;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0] m_mem [64];
    logic [6:0] m_idx;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    cfgram_top i_cfgram_top (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .rdy   (rdy)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] m_sum();
        logic [15:0] s = '0;
        for (int a = 16; a <= 44; a++) s = s + {8'h00, m_mem[a]};
        return s;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // monitor: pops expected result on every cycle with rdy high
    always @(negedge clk) begin
        cyc++;
        if (rst_n && rdy === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rdy", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
        if (cyc > 20000) begin
            check("watchdog", 8'h01, 8'h00);
            finish_run();
        end
    end

    task automatic rd(input logic s, input string tag);
        @(negedge clk);
        sel = s; rd_en = 1'b1; wr_en = 1'b0;
        exp_q.push_back(s ? m_mem[m_idx[5:0]] : {1'b0, m_idx});
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr_en = 1'b1; rd_en = 1'b0; wdata = d;
        if (!s) m_idx = d[6:0];
        else begin
            m_mem[m_idx[5:0]] = d;
            if (m_idx[5:0] >= 6'h10 && m_idx[5:0] <= 6'h2C) begin
                m_mem[46] = m_sum() >> 8;
                m_mem[47] = m_sum() & 16'hFF;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] a, input string tag);
        wr(1'b0, a);
        rd(1'b1, tag);
    endtask

    initial begin
        for (int a = 0; a < 64; a++)
            m_mem[a] = (a >= 16 && a <= 44) ? 8'((3 * a + 1) % 256) : 8'h00;
        m_mem[10] = 8'h26; m_mem[11] = 8'h02; m_mem[12] = 8'h50; m_mem[13] = 8'h80;
        m_mem[46] = 8'h0A; m_mem[47] = 8'h4F;
        m_idx = '0;

        repeat (3) @(negedge clk);
        check("R1 rdy in reset", {7'd0, rdy}, 8'h00);
        check("R1 rdata in reset", rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdy after reset", {7'd0, rdy}, 8'h00);
        rd(1'b0, "R1 index after reset");

        rd_at(8'h0A, "R4 loc 0A"); rd_at(8'h0B, "R4 loc 0B");
        rd_at(8'h0C, "R4 loc 0C"); rd_at(8'h0D, "R4 loc 0D");
        rd_at(8'h10, "R4 loc 10"); rd_at(8'h2C, "R4 loc 2C");
        rd_at(8'h3F, "R4 loc 3F");
        rd_at(8'h2E, "R5 checksum high"); rd_at(8'h2F, "R5 checksum low");
        check("R5 model high", m_mem[46], 8'h0A);

        wr(1'b0, 8'hC5);
        rd(1'b0, "R2 index masked");
        rd(1'b1, "R3 alias read loc 05");
        wr(1'b1, 8'h77);
        rd_at(8'h05, "R3 alias write seen at 05");

        wr(1'b0, 8'h20); wr(1'b1, 8'hFF);
        rd_at(8'h2E, "R6 checksum high after write");
        rd_at(8'h2F, "R6 checksum low after write");

        rd_at(8'h2E, "R8 before");
        wr(1'b0, 8'h31); wr(1'b1, 8'hA5);
        rd_at(8'h2E, "R8 high unchanged"); rd_at(8'h2F, "R8 low unchanged");

        wr(1'b0, 8'h2E); wr(1'b1, 8'h99);
        rd(1'b1, "R7 direct write stored");
        wr(1'b0, 8'h11); wr(1'b1, 8'h00);
        rd_at(8'h2E, "R7 high restored"); rd_at(8'h2F, "R7 low restored");

        // R9: back-to-back reads, then rdy must drop after one cycle
        wr(1'b0, 8'h0B);
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1;
        exp_q.push_back(m_mem[11]); tag_q.push_back("R9 back-to-back first");
        @(negedge clk);
        exp_q.push_back(m_mem[11]); tag_q.push_back("R9 back-to-back second");
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check("R9 rdy single cycle", {7'd0, rdy}, 8'h00);
        check("R10 rdata held", rdata, m_mem[11]);

        // R11: both strobes high on data port at location 0x30
        wr(1'b0, 8'h30);
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1; wr_en = 1'b1; wdata = 8'h5A;
        m_mem[48] = 8'h5A;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R11 no response", {7'd0, rdy}, 8'h00);
        check("R11 rdata unchanged", rdata, m_mem[11]);
        rd(1'b1, "R11 write performed");

        repeat (2) @(negedge clk);
        check("R9 queue drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule